// File: doc/BRIEF.md
# Serial Outer-Bank Latch with Work-RAM Bank Select

This block sits in front of a serial bank controller on a multi-game cartridge. The CPU loads a 4-bit outer-bank value one bit per write. Each write that lands in the 0x5000-0x5FFF window supplies bit 3 of its data byte. The bits arrive least significant first. After four such writes the collected value becomes the new outer bank.

The outer bank is merged with the bank numbers from the inner controller to produce three outputs. The first is a wide 16 KiB program-ROM bank. The second is a 4 KiB pattern bank. The third is the 8 KiB slot chosen from a 64 KiB work RAM. The RAM slot follows one of two rules, selected by outer bit 1. One rule uses only outer bits. The other also draws on a bit of the first pattern bank number. The bank outputs are combinational from the outer register and the inner inputs.

Top module: `serial_outer_bank`

## Requirements
- R1: A write with `wr_en` high and `wr_addr[15:12]` equal to 4'h5 places `wr_data[3]` at the current bit position (first write = bit 0). The outer bank does not change on the first three writes of a group.
- R2: On the clock edge of the fourth in-window write, the outer bank takes the four collected bits (the fourth write's bit as bit 3). The collector and its count then clear, so the next write starts a new group at bit 0.
- R3: A cycle with `wr_en` low, or with `wr_addr[15:12]` not equal to 4'h5, neither advances the count nor changes the outer bank.
- R4: `prg_bank[7:4]` equals the outer bank and `prg_bank[3:0]` equals `inner_prg`.
- R5: `chr_bank` equals `inner_chr[2:0]` whatever the outer bank holds.
- R6: When outer bit 1 is 1, `ram_bank` is {1, outer[2], outer[0]}.
- R7: When outer bit 1 is 0, `ram_bank` is {0, outer[0], inner_chr0[3]}.
- R8: Active-low `rst_n` clears the outer bank, the collected bits and the count. A partial group in progress at reset is discarded.
- R9: Data bits other than bit 3 have no effect on the collected value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| inner_prg | input | 4 | 16 KiB program bank number from the inner controller |
| inner_chr | input | 5 | 4 KiB pattern bank number being translated |
| inner_chr0 | input | 5 | First pattern bank number of the inner controller |
| prg_bank | output | 8 | Combined 16 KiB program-ROM bank |
| chr_bank | output | 3 | 4 KiB pattern bank |
| ram_bank | output | 3 | 8 KiB work-RAM slot within 64 KiB |

## Verification
The assertions assume that `wr_en` marks at most one write per cycle. They also assume that the inner bank inputs are held steady by their source, so the bank outputs are pure functions of the outer register and those inputs in every cycle. The stimulus follows these assumptions. Each write lasts exactly one cycle. Inner bank values change only between writes, on the falling edge.

Groups of four writes carry random payloads and random unused data bits. Between writes, the stimulus inserts idle cycles and writes just outside the window at 0x4FFF and 0x6000. A reset is applied in the middle of a partial group.

// File: rtl/obl_pkg.sv
package obl_pkg;
    localparam int OUTER_W = 4;
    localparam int CNT_W   = $clog2(OUTER_W);

    typedef struct packed {
        logic [OUTER_W-1:0] acc;
        logic [CNT_W-1:0]   cnt;
        logic [OUTER_W-1:0] outer;
    } ser_state_t;
endpackage

// File: rtl/obl_serial_acc.sv
module obl_serial_acc
    import obl_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 8,
    parameter int          DATA_BIT = 3,
    parameter logic [3:0]  WIN_NIB  = 4'h5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                hit,
    output logic [CNT_W-1:0]    cnt,
    output logic [OUTER_W-1:0]  outer
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OUTER_W - 1);

    ser_state_t         st_d, st_q;
    logic [OUTER_W-1:0] merged;
    logic [ADDR_W-5:0]  unused_addr_lo;
    logic [DATA_W-1:0]  unused_data;

    assign unused_addr_lo = wr_addr[ADDR_W-5:0];
    assign unused_data    = wr_data;

    assign hit = wr_en && (wr_addr[ADDR_W-1 -: 4] == WIN_NIB);

    always_comb begin
        st_d   = st_q;
        merged = st_q.acc;
        merged[st_q.cnt] = wr_data[DATA_BIT];
        if (hit) begin
            if (st_q.cnt == LAST) begin
                st_d.outer = merged;
                st_d.acc   = '0;
                st_d.cnt   = '0;
            end else begin
                st_d.acc = merged;
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt   = st_q.cnt;
    assign outer = st_q.outer;
endmodule

// File: rtl/obl_bank_map.sv
module obl_bank_map
    import obl_pkg::*;
#(
    parameter int PRG_LO_W    = 4,
    parameter int CHR_IN_W    = 5,
    parameter int CHR_KEEP_W  = 3,
    parameter int CHR_RAM_BIT = 3,
    parameter int RAM_W       = 3
) (
    input  logic [OUTER_W-1:0]          outer,
    input  logic [PRG_LO_W-1:0]         inner_prg,
    input  logic [CHR_IN_W-1:0]         inner_chr,
    input  logic [CHR_IN_W-1:0]         inner_chr0,
    output logic [OUTER_W+PRG_LO_W-1:0] prg_bank,
    output logic [CHR_KEEP_W-1:0]       chr_bank,
    output logic [RAM_W-1:0]            ram_bank
);
    logic [CHR_IN_W-1:0] unused_chr;

    assign unused_chr = inner_chr ^ inner_chr0;

    assign prg_bank = {outer, inner_prg};
    assign chr_bank = inner_chr[CHR_KEEP_W-1:0];

    always_comb begin
        if (outer[1]) ram_bank = {1'b1, outer[2], outer[0]};
        else          ram_bank = {1'b0, outer[0], inner_chr0[CHR_RAM_BIT]};
    end
endmodule

// File: rtl/serial_outer_bank.sv
module serial_outer_bank
    import obl_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int PRG_LO_W   = 4,
    parameter int CHR_IN_W   = 5,
    parameter int CHR_KEEP_W = 3,
    parameter int RAM_W      = 3,
    localparam int PRG_W     = OUTER_W + PRG_LO_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [PRG_LO_W-1:0]   inner_prg,
    input  logic [CHR_IN_W-1:0]   inner_chr,
    input  logic [CHR_IN_W-1:0]   inner_chr0,
    output logic [PRG_W-1:0]      prg_bank,
    output logic [CHR_KEEP_W-1:0] chr_bank,
    output logic [RAM_W-1:0]      ram_bank
);
    logic               hit;
    logic [CNT_W-1:0]   cnt;
    logic [OUTER_W-1:0] outer;

    obl_serial_acc #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .DATA_BIT(3),
        .WIN_NIB (4'h5)
    ) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .hit    (hit),
        .cnt    (cnt),
        .outer  (outer)
    );

    obl_bank_map #(
        .PRG_LO_W   (PRG_LO_W),
        .CHR_IN_W   (CHR_IN_W),
        .CHR_KEEP_W (CHR_KEEP_W),
        .CHR_RAM_BIT(3),
        .RAM_W      (RAM_W)
    ) u_map (
        .outer     (outer),
        .inner_prg (inner_prg),
        .inner_chr (inner_chr),
        .inner_chr0(inner_chr0),
        .prg_bank  (prg_bank),
        .chr_bank  (chr_bank),
        .ram_bank  (ram_bank)
    );
endmodule

// File: rtl/obl_checker.sv
module obl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       hit,
    input logic [1:0] cnt,
    input logic [3:0] outer,
    input logic [3:0] inner_prg,
    input logic [4:0] inner_chr,
    input logic [4:0] inner_chr0,
    input logic [7:0] prg_bank,
    input logic [2:0] chr_bank,
    input logic [2:0] ram_bank
);
    // R3: no decoded write, nothing moves
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> ($stable(outer) && $stable(cnt)));

    // R1: partial group keeps outer and steps the count
    a_r1_partial_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cnt != 2'd3) |=> ($stable(outer) && cnt == $past(cnt) + 2'd1));

    // R2: fourth write restarts the count
    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cnt == 2'd3) |=> (cnt == 2'd0));

    // R4
    a_r4_prg_join: assert property (@(posedge clk) disable iff (!rst_n)
        (prg_bank[7:4] == outer) && (prg_bank[3:0] == inner_prg));

    // R5
    a_r5_chr_low: assert property (@(posedge clk) disable iff (!rst_n)
        chr_bank == inner_chr[2:0]);

    // R6
    a_r6_ram_upper: assert property (@(posedge clk) disable iff (!rst_n)
        outer[1] |-> (ram_bank[2] && ram_bank[1] == outer[2] && ram_bank[0] == outer[0]));

    // R7
    a_r7_ram_lower: assert property (@(posedge clk) disable iff (!rst_n)
        !outer[1] |-> (!ram_bank[2] && ram_bank[1] == outer[0] && ram_bank[0] == inner_chr0[3]));
endmodule

bind serial_outer_bank obl_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (hit),
    .cnt       (cnt),
    .outer     (outer),
    .inner_prg (inner_prg),
    .inner_chr (inner_chr),
    .inner_chr0(inner_chr0),
    .prg_bank  (prg_bank),
    .chr_bank  (chr_bank),
    .ram_bank  (ram_bank)
);

// File: tb/serial_outer_bank_tb.sv
module serial_outer_bank_tb;
    typedef struct {
        logic [7:0] prg;
        logic [2:0] chr;
        logic [2:0] ram;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [3:0]  inner_prg = '0;
    logic [4:0]  inner_chr = '0;
    logic [4:0]  inner_chr0 = '0;
    logic [7:0]  prg_bank;
    logic [2:0]  chr_bank;
    logic [2:0]  ram_bank;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [3:0] m_outer = '0;
    exp_t q[$];

    always #4 clk = ~clk;

    serial_outer_bank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .inner_prg(inner_prg), .inner_chr(inner_chr),
        .inner_chr0(inner_chr0), .prg_bank(prg_bank), .chr_bank(chr_bank),
        .ram_bank(ram_bank)
    );

    function automatic logic [2:0] model_ram(logic [3:0] o, logic [4:0] c0);
        if (o[1]) return {1'b1, o[2], o[0]};
        return {1'b0, o[0], c0[3]};
    endfunction

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_bit(input logic b);
        logic [7:0] d;
        d = 8'($urandom);
        d[3] = b;
        wr(16'h5000 | 16'($urandom_range(0, 16'h0FFF)), d);
    endtask

    task automatic send_outer(input logic [3:0] v);
        for (int i = 0; i < 4; i++) wr_bit(v[i]);
        m_outer = v;
    endtask

    task automatic expect_now(input string tag);
        exp_t e;
        @(negedge clk);
        inner_prg  = 4'($urandom);
        inner_chr  = 5'($urandom);
        inner_chr0 = 5'($urandom);
        e.prg = {m_outer, inner_prg};
        e.chr = inner_chr[2:0];
        e.ram = model_ram(m_outer, inner_chr0);
        e.tag = tag;
        q.push_back(e);
        wait (q.size() == 0);
        #2;
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            wait (q.size() > 0);
            #1;
            e = q.pop_front();
            checks++;
            if (prg_bank !== e.prg) begin
                errors++;
                $display("FAIL %s R4 prg_bank actual %h expected %h", e.tag, prg_bank, e.prg);
            end
            checks++;
            if (chr_bank !== e.chr) begin
                errors++;
                $display("FAIL %s R5 chr_bank actual %h expected %h", e.tag, chr_bank, e.chr);
            end
            checks++;
            if (ram_bank !== e.ram) begin
                errors++;
                $display("FAIL %s R6/R7 ram_bank actual %h expected %h", e.tag, ram_bank, e.ram);
            end
        end
    end

    initial begin : watchdog
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_now("R8 reset state");

        // R6 and R7 directed values
        send_outer(4'b0010); expect_now("R6 outer 0010");
        send_outer(4'b1111); expect_now("R6 outer 1111");
        send_outer(4'b0101); expect_now("R7 outer 0101");
        expect_now("R7 chr0 bit varies");
        send_outer(4'b0000); expect_now("R7 outer 0000");

        // R1: partial group leaves outer as it was
        send_outer(4'b1001); expect_now("R2 outer 1001");
        wr_bit(1'b0); wr_bit(1'b1);
        expect_now("R1 after two writes");
        wr_bit(1'b1);
        expect_now("R1 after three writes");
        wr_bit(1'b0);
        m_outer = 4'b0110;
        expect_now("R2 fourth write loads 0110");

        // R3 and R9: ignored cycles and ignored data bits
        send_outer(4'b1111);
        wr(16'h5123, 8'hF7); wr(16'h5FFF, 8'h00); wr(16'h5000, 8'hF7);
        wr(16'h4FFF, 8'h08); wr(16'h6000, 8'h08);
        @(negedge clk); wr_en = 1'b0; wr_addr = 16'h5000; wr_data = 8'h08;
        @(negedge clk);
        expect_now("R3 out of window and idle ignored");
        wr(16'h5ABC, 8'hF7);
        m_outer = 4'b0000;
        expect_now("R9 other data bits ignored");
        send_outer(4'b1000); expect_now("R2 next group starts at bit 0");

        // R8: reset inside a partial group
        wr_bit(1'b1); wr_bit(1'b1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_outer = 4'b0000;
        expect_now("R8 reset clears outer");
        send_outer(4'b0001); expect_now("R8 partial group discarded");

        // random groups
        for (int k = 0; k < 40; k++) begin
            send_outer(4'($urandom));
            expect_now("R2 random group");
            expect_now("R5 random inner values");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule